// File: doc/BRIEF.md
# Uncorrectable/Correctable Error Status with Multi-Header Recording

This block holds the error status of a memory device. Uncorrectable errors are recorded one by one. Each accepted injection becomes a record that carries an error type and a header log of up to `HDR_WORDS` dwords, and the records wait in arrival order. The first-error pointer and the header-log read window always describe the oldest record. The uncorrectable status register is not a set of free-standing bits. It reads as the union of the types of all waiting records.

Software retires records by writing the uncorrectable status. A write of exactly the pointer's one-hot bit retires the oldest record, and the next record then moves up into the pointer and the header window. Any other write value retires every record whose type bit it carries. Correctable errors use a simple sticky register that is cleared by writing ones. Both kinds honour mask inputs, and each accepted injection produces a one-cycle pulse.

A header is built by streaming dwords on `hdr_push` and then committing the record with `unc_inj`. The commit takes the words streamed since the previous commit.

Top module: `err_status_hq`

## Requirements
- R1: An uncorrectable injection whose type bit is set in `unc_mask` is dropped: no record is queued, `unc_accept` stays low and `unc_status` is unchanged.
- R2: A record carries the dwords streamed since the last commit, zero-filled up to `HDR_WORDS`. If more than `HDR_WORDS` dwords were streamed, the commit is rejected, nothing is queued, and `hdr_len_err` is high for one cycle after it.
- R3: When the queue goes from empty to non-empty, `first_err_ptr` equals the new record's type, and `hdr_log_word` at index `hdr_sel` equals that record's dword at that index.
- R4: A status write whose value equals exactly `1 << first_err_ptr` removes only the oldest record, even if later records share its type.
- R5: Any other status write on a non-empty queue removes every record whose type bit (bit number = type) is set in `wr_data`. Remaining records keep their order.
- R6: After a removal, pointer and header window show the new oldest record. An empty queue shows pointer 63 (all ones in the 6-bit field) and header words of zero.
- R7: `unc_status` bit t is set exactly when a queued record has type t.
- R8: An unmasked correctable injection of type t sets `cor_status` bit t. A `cor_wr` clears the bits that are one in `wr_data`. A masked injection changes nothing. When a set and a clear hit the same bit in one cycle, the set wins.
- R9: At most `DEPTH` (default 8) records are held. An unmasked, well-formed injection into a full queue is dropped and sets the sticky `queue_ovf`.
- R10: `unc_accept` and `cor_accept` are high for exactly the one cycle after each accepted injection, in the same cycle in which the status shows its effect.
- R11: After reset, both status registers read 0, the pointer reads 63, and all flags and pulses are low.
- R12: In a cycle with both a status write and an uncorrectable injection, the removal is applied first. The injection then sees the space the removal freed and is appended as the newest record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_push | input | 1 | Stream one header dword into the staging buffer |
| hdr_word | input | WORD_W (32) | Header dword being streamed |
| unc_inj | input | 1 | Commit an uncorrectable record with the staged header |
| unc_inj_type | input | TYPE_W (5) | Type of the committed uncorrectable error |
| cor_inj | input | 1 | Inject a correctable error |
| cor_inj_type | input | TYPE_W (5) | Type of the correctable error |
| unc_mask | input | 2**TYPE_W (32) | Uncorrectable mask, bit t drops type t |
| cor_mask | input | 2**TYPE_W (32) | Correctable mask, bit t drops type t |
| unc_wr | input | 1 | Software write to the uncorrectable status |
| cor_wr | input | 1 | Software write-1-to-clear to the correctable status |
| wr_data | input | 2**TYPE_W (32) | Value of the status write |
| hdr_sel | input | log2(HDR_WORDS) (5) | Dword index of the header window |
| unc_status | output | 2**TYPE_W (32) | Union of queued record types |
| cor_status | output | 2**TYPE_W (32) | Correctable status |
| first_err_ptr | output | PTR_W (6) | Type of the oldest record, 63 when empty |
| hdr_log_word | output | WORD_W (32) | Oldest record's header dword at `hdr_sel` |
| unc_accept | output | 1 | Pulse: uncorrectable record queued |
| cor_accept | output | 1 | Pulse: correctable error recorded |
| hdr_len_err | output | 1 | Pulse: commit rejected for an overlong header |
| queue_ovf | output | 1 | Sticky: a record was lost to a full queue |

## Verification
The queue is driven with records whose types repeat, so that head-only removal (one-hot write equal to the pointer) can be told apart from remove-all-matching. The same one-hot value is written while a later record shares the head's type. Mixed multi-bit writes are used to show that order is kept after compaction. A run that fills the queue, followed by a write and an injection in the same cycle, tells dropping from appending into freed space. Header lengths of 0, 32 and 33 dwords probe zero fill and the length limit. A long random phase with a narrow type range checks the queue against a behavioural model every clock.

// File: rtl/errq_pkg.sv
// Shared definitions for the error header queue.
// Assumes: users import the removal-kind encoding from here.
package errq_pkg;

    // What a status write asks the record list to retire.
    typedef enum logic [1:0] {
        CLR_NONE  = 2'd0,
        CLR_HEAD  = 2'd1,
        CLR_MATCH = 2'd2
    } errq_clr_e;

endpackage

// File: rtl/errq_stage.sv
// Staging buffer that gathers header dwords for the next record.
// It counts dwords beyond the capacity so that an overlong header can be
// rejected. A commit ('take') empties the buffer. A dword pushed in the
// commit cycle becomes word 0 of the following record.
module errq_stage #(
    parameter int HDR_WORDS = 32,
    parameter int WORD_W    = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               push,
    input  logic [WORD_W-1:0]                  word,
    input  logic                               take,
    output logic [HDR_WORDS-1:0][WORD_W-1:0]   words,
    output logic                               too_long
);
    localparam int IDX_W = $clog2(HDR_WORDS);
    localparam int CNT_W = $clog2(HDR_WORDS + 2);

    logic [CNT_W-1:0] cnt;

    // Collect dwords; saturate the count one past capacity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
            cnt   <= '0;
        end else if (take) begin
            words <= '0;
            cnt   <= push ? CNT_W'(1) : '0;
            if (push) words[0] <= word;
        end else if (push) begin
            if (cnt < CNT_W'(HDR_WORDS)) words[IDX_W'(cnt)] <= word;
            if (cnt <= CNT_W'(HDR_WORDS)) cnt <= cnt + 1'b1;
        end
    end

    // Overlong when more dwords arrived than a record holds.
    always_comb too_long = (cnt > CNT_W'(HDR_WORDS));

    AST_STAGE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(HDR_WORDS + 1));  // R2
    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !push) |=> (cnt == '0));  // R2
endmodule

// File: rtl/errq_order.sv
// Ordered list of queued uncorrectable records. Each entry holds a type and
// the pool slot where its header lives. Position 0 is the oldest record.
// A removal may drop the head or any set of matching entries. Survivors are
// compacted toward position 0, and then an append uses the freed space.
// Assumes: DEPTH >= 2.
module errq_order
    import errq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TYPE_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  errq_clr_e                     clr_kind,
    input  logic [(1<<TYPE_W)-1:0]        clr_bits,
    input  logic                          push_req,
    input  logic [TYPE_W-1:0]             push_type,
    output logic                          push_ok,
    output logic [$clog2(DEPTH)-1:0]      alloc_slot,
    output logic [$clog2(DEPTH)-1:0]      head_slot,
    output logic [TYPE_W-1:0]             head_type,
    output logic                          nonempty,
    output logic [(1<<TYPE_W)-1:0]        status
);
    localparam int SLOT_W    = $clog2(DEPTH);
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int NUM_TYPES = 1 << TYPE_W;

    logic [DEPTH-1:0][SLOT_W-1:0] ord_slot, n_slot;
    logic [DEPTH-1:0][TYPE_W-1:0] ord_type, n_type;
    logic [CNT_W-1:0]             cnt, n_cnt, kept;
    logic [DEPTH-1:0]             used, n_used, avail, freed, drop;

    // Decide survivors, compact them, pick a free slot and append.
    always_comb begin
        drop    = '0;
        freed   = '0;
        n_slot  = '0;
        n_type  = '0;
        kept    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < cnt) begin
                case (clr_kind)
                    CLR_HEAD:  drop[i] = (i == 0);
                    CLR_MATCH: drop[i] = clr_bits[ord_type[i]];
                    default:   drop[i] = 1'b0;
                endcase
                if (drop[i]) begin
                    freed[ord_slot[i]] = 1'b1;
                end else begin
                    n_slot[SLOT_W'(kept)] = ord_slot[i];
                    n_type[SLOT_W'(kept)] = ord_type[i];
                    kept = kept + 1'b1;
                end
            end
        end
        avail      = used & ~freed;
        alloc_slot = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (!avail[k]) alloc_slot = SLOT_W'(k);
        end
        push_ok = push_req && (kept < CNT_W'(DEPTH));
        n_used  = avail;
        n_cnt   = kept;
        if (push_ok) begin
            n_slot[SLOT_W'(kept)] = alloc_slot;
            n_type[SLOT_W'(kept)] = push_type;
            n_used[alloc_slot]    = 1'b1;
            n_cnt                 = kept + 1'b1;
        end
    end

    // Hold the ordered list, its length and the slot occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ord_slot <= '0;
            ord_type <= '0;
            cnt      <= '0;
            used     <= '0;
        end else begin
            ord_slot <= n_slot;
            ord_type <= n_type;
            cnt      <= n_cnt;
            used     <= n_used;
        end
    end

    // Union of the types of all live entries.
    always_comb begin
        status = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < cnt) status[ord_type[i]] = 1'b1;
        end
    end

    // Head view for the pointer and the header window.
    always_comb begin
        head_slot = ord_slot[0];
        head_type = ord_type[0];
        nonempty  = (cnt != '0);
    end

    AST_HEAD_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_kind == CLR_HEAD && !push_req) |=> (cnt == $past(cnt) - 1'b1));  // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));  // R9
    AST_SLOTS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(used) == int'(cnt));  // R9
    AST_MATCH_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_kind == CLR_MATCH && !push_req) |=> ((status & $past(clr_bits)) == '0));  // R5

    logic unused_types;
    always_comb unused_types = ^NUM_TYPES;
endmodule

// File: rtl/errq_hdr_store.sv
// Header pool: one row of HDR_WORDS dwords per record slot. A whole row is
// written when a record is queued, and any single dword can be read
// combinationally. Assumes: the reader ignores the data of an empty queue,
// so the pool has no reset.
module errq_hdr_store #(
    parameter int DEPTH     = 8,
    parameter int HDR_WORDS = 32,
    parameter int WORD_W    = 32
) (
    input  logic                               clk,
    input  logic                               we,
    input  logic [$clog2(DEPTH)-1:0]           wslot,
    input  logic [HDR_WORDS-1:0][WORD_W-1:0]   wrow,
    input  logic [$clog2(DEPTH)-1:0]           rslot,
    input  logic [$clog2(HDR_WORDS)-1:0]       ridx,
    output logic [WORD_W-1:0]                  rdata
);
    logic [DEPTH-1:0][HDR_WORDS-1:0][WORD_W-1:0] mem;

    // Row write for a newly queued record.
    always_ff @(posedge clk) begin
        if (we) mem[wslot] <= wrow;
    end

    // Single-dword read of the selected row.
    always_comb rdata = mem[rslot][ridx];
endmodule

// File: rtl/errq_cor.sv
// Correctable status: sticky bits set by unmasked injections and cleared by
// writing ones. A set wins over a clear of the same bit in the same cycle.
module errq_cor #(
    parameter int TYPE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inj,
    input  logic [TYPE_W-1:0]        itype,
    input  logic [(1<<TYPE_W)-1:0]   mask,
    input  logic                     wr,
    input  logic [(1<<TYPE_W)-1:0]   wdata,
    output logic [(1<<TYPE_W)-1:0]   status,
    output logic                     accept
);
    localparam int NUM_TYPES = 1 << TYPE_W;

    logic                 take;
    logic [NUM_TYPES-1:0] set_bits, clr_bits;

    // Decode the injection and the clear into bit vectors.
    always_comb begin
        take     = inj && !mask[itype];
        set_bits = take ? (NUM_TYPES'(1) << itype) : '0;
        clr_bits = wr ? wdata : '0;
    end

    // Apply clear then set; pulse on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            accept <= 1'b0;
        end else begin
            status <= (status & ~clr_bits) | set_bits;
            accept <= take;
        end
    end

    AST_COR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !inj) |=> ((status & $past(wdata)) == '0));  // R8
    AST_COR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (inj && !mask[itype]) |=> status[$past(itype)]);  // R8
endmodule

// File: rtl/err_status_hq.sv
// Error status block with multi-header recording for uncorrectable errors.
// It stages header dwords, gates injections by mask and length, classifies
// status writes as head-pop or match-removal, and presents the oldest record
// through the first-error pointer and the header window.
// Assumes: PTR_W > TYPE_W, so the all-ones pointer is never a real type.
module err_status_hq
    import errq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int HDR_WORDS = 32,
    parameter int WORD_W    = 32,
    parameter int TYPE_W    = 5,
    parameter int PTR_W     = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hdr_push,
    input  logic [WORD_W-1:0]              hdr_word,
    input  logic                           unc_inj,
    input  logic [TYPE_W-1:0]              unc_inj_type,
    input  logic                           cor_inj,
    input  logic [TYPE_W-1:0]              cor_inj_type,
    input  logic [(1<<TYPE_W)-1:0]         unc_mask,
    input  logic [(1<<TYPE_W)-1:0]         cor_mask,
    input  logic                           unc_wr,
    input  logic                           cor_wr,
    input  logic [(1<<TYPE_W)-1:0]         wr_data,
    input  logic [$clog2(HDR_WORDS)-1:0]   hdr_sel,
    output logic [(1<<TYPE_W)-1:0]         unc_status,
    output logic [(1<<TYPE_W)-1:0]         cor_status,
    output logic [PTR_W-1:0]               first_err_ptr,
    output logic [WORD_W-1:0]              hdr_log_word,
    output logic                           unc_accept,
    output logic                           cor_accept,
    output logic                           hdr_len_err,
    output logic                           queue_ovf
);
    localparam int NUM_TYPES = 1 << TYPE_W;
    localparam int SLOT_W    = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_NONE = {PTR_W{1'b1}};

    logic [HDR_WORDS-1:0][WORD_W-1:0] stage_words;
    logic                             too_long;
    logic                             push_req, push_ok, nonempty;
    logic [SLOT_W-1:0]                alloc_slot, head_slot;
    logic [TYPE_W-1:0]                head_type;
    logic [NUM_TYPES-1:0]             head_bit;
    logic [WORD_W-1:0]                store_word;
    errq_clr_e                        clr_kind;

    errq_stage #(.HDR_WORDS(HDR_WORDS), .WORD_W(WORD_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (hdr_push),
        .word     (hdr_word),
        .take     (unc_inj),
        .words    (stage_words),
        .too_long (too_long)
    );

    // Admission: well-formed header and unmasked type.
    always_comb push_req = unc_inj && !too_long && !unc_mask[unc_inj_type];

    // Classify a status write against the current first-error bit.
    always_comb begin
        head_bit = NUM_TYPES'(1) << head_type;
        if (!unc_wr || !nonempty)   clr_kind = CLR_NONE;
        else if (wr_data == head_bit) clr_kind = CLR_HEAD;
        else                        clr_kind = CLR_MATCH;
    end

    errq_order #(.DEPTH(DEPTH), .TYPE_W(TYPE_W)) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_kind   (clr_kind),
        .clr_bits   (wr_data),
        .push_req   (push_req),
        .push_type  (unc_inj_type),
        .push_ok    (push_ok),
        .alloc_slot (alloc_slot),
        .head_slot  (head_slot),
        .head_type  (head_type),
        .nonempty   (nonempty),
        .status     (unc_status)
    );

    errq_hdr_store #(.DEPTH(DEPTH), .HDR_WORDS(HDR_WORDS), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (push_ok),
        .wslot (alloc_slot),
        .wrow  (stage_words),
        .rslot (head_slot),
        .ridx  (hdr_sel),
        .rdata (store_word)
    );

    errq_cor #(.TYPE_W(TYPE_W)) u_cor (
        .clk    (clk),
        .rst_n  (rst_n),
        .inj    (cor_inj),
        .itype  (cor_inj_type),
        .mask   (cor_mask),
        .wr     (cor_wr),
        .wdata  (wr_data),
        .status (cor_status),
        .accept (cor_accept)
    );

    // Present the oldest record, or the reserved pointer when empty.
    always_comb begin
        first_err_ptr = nonempty ? PTR_W'(head_type) : PTR_NONE;
        hdr_log_word  = nonempty ? store_word : '0;
    end

    // Pulses and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unc_accept  <= 1'b0;
            hdr_len_err <= 1'b0;
            queue_ovf   <= 1'b0;
        end else begin
            unc_accept  <= push_ok;
            hdr_len_err <= unc_inj && too_long;
            queue_ovf   <= queue_ovf || (push_req && !push_ok);
        end
    end

    AST_MASKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_inj && unc_mask[unc_inj_type]) |=> !unc_accept);  // R1
    AST_LONG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_inj && too_long) |=> (!unc_accept && hdr_len_err));  // R2
    AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_status == '0) |-> (first_err_ptr == PTR_NONE));  // R6
    AST_FE_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (first_err_ptr != PTR_NONE) |-> unc_status[first_err_ptr[TYPE_W-1:0]]);  // R7
    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        queue_ovf |=> queue_ovf);  // R9
    AST_ACCEPT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        unc_accept |-> (unc_status != '0));  // R10
endmodule

// File: tb/err_status_hq_bench.sv
// Bench: behavioural reference model (queues) compared every clock, plus
// directed checks with hand-computed values.
module err_status_hq_bench;
    localparam int DEPTH = 8;
    localparam int HW    = 32;

    typedef logic [HW-1:0][31:0] hdr_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_push = 1'b0;
    logic [31:0] hdr_word = '0;
    logic        unc_inj = 1'b0;
    logic [4:0]  unc_inj_type = '0;
    logic        cor_inj = 1'b0;
    logic [4:0]  cor_inj_type = '0;
    logic [31:0] unc_mask = '0;
    logic [31:0] cor_mask = '0;
    logic        unc_wr = 1'b0;
    logic        cor_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  hdr_sel = '0;
    logic [31:0] unc_status, cor_status, hdr_log_word;
    logic [5:0]  first_err_ptr;
    logic        unc_accept, cor_accept, hdr_len_err, queue_ovf;

    err_status_hq u_err_status_hq (
        .clk(clk), .rst_n(rst_n), .hdr_push(hdr_push), .hdr_word(hdr_word),
        .unc_inj(unc_inj), .unc_inj_type(unc_inj_type),
        .cor_inj(cor_inj), .cor_inj_type(cor_inj_type),
        .unc_mask(unc_mask), .cor_mask(cor_mask),
        .unc_wr(unc_wr), .cor_wr(cor_wr), .wr_data(wr_data), .hdr_sel(hdr_sel),
        .unc_status(unc_status), .cor_status(cor_status),
        .first_err_ptr(first_err_ptr), .hdr_log_word(hdr_log_word),
        .unc_accept(unc_accept), .cor_accept(cor_accept),
        .hdr_len_err(hdr_len_err), .queue_ovf(queue_ovf)
    );

    always #10 clk = ~clk;  // 50 MHz

    int total = 0;
    int fails = 0;

    // Reference model state
    int          m_type[$];
    hdr_t        m_hdr[$];
    hdr_t        m_stage;
    int          m_scnt;
    logic [31:0] m_cor;
    logic        m_ovf, m_uacc, m_cacc, m_lerr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_type.delete(); m_hdr.delete();
            m_stage = '0; m_scnt = 0; m_cor = '0;
            m_ovf = 0; m_uacc = 0; m_cacc = 0; m_lerr = 0;
        end else begin
            m_uacc = 0; m_cacc = 0; m_lerr = 0;
            if (unc_wr && m_type.size() > 0) begin
                if (wr_data == (32'd1 << m_type[0])) begin
                    m_type.delete(0); m_hdr.delete(0);
                end else begin
                    for (int i = m_type.size() - 1; i >= 0; i--) begin
                        if (wr_data[m_type[i]]) begin
                            m_type.delete(i); m_hdr.delete(i);
                        end
                    end
                end
            end
            if (unc_inj) begin
                if (m_scnt > HW) m_lerr = 1;
                else if (!unc_mask[unc_inj_type]) begin
                    if (m_type.size() < DEPTH) begin
                        m_type.push_back(int'(unc_inj_type));
                        m_hdr.push_back(m_stage);
                        m_uacc = 1;
                    end else m_ovf = 1;
                end
                m_stage = '0; m_scnt = 0;
            end
            if (hdr_push) begin
                if (m_scnt < HW) m_stage[m_scnt] = hdr_word;
                if (m_scnt <= HW) m_scnt++;
            end
            if (cor_wr) m_cor = m_cor & ~wr_data;
            if (cor_inj && !cor_mask[cor_inj_type]) begin
                m_cor[cor_inj_type] = 1'b1; m_cacc = 1;
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] es;
        es = '0;
        foreach (m_type[i]) es[m_type[i]] = 1'b1;
        chk("R7 unc_status", 64'(unc_status), 64'(es));
        chk("R6 first_err_ptr", 64'(first_err_ptr),
            64'(m_type.size() > 0 ? m_type[0] : 63));
        chk("R3 hdr_log_word", 64'(hdr_log_word),
            64'(m_type.size() > 0 ? m_hdr[0][hdr_sel] : 32'd0));
        chk("R8 cor_status", 64'(cor_status), 64'(m_cor));
        chk("R9 queue_ovf", 64'(queue_ovf), 64'(m_ovf));
        chk("R10 unc_accept", 64'(unc_accept), 64'(m_uacc));
        chk("R10 cor_accept", 64'(cor_accept), 64'(m_cacc));
        chk("R2 hdr_len_err", 64'(hdr_len_err), 64'(m_lerr));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) compare_all();
        hdr_push = 0; unc_inj = 0; cor_inj = 0; unc_wr = 0; cor_wr = 0;
    endtask

    task automatic push_hdr(int n, int base);
        for (int k = 0; k < n; k++) begin
            hdr_word = 32'(base + k); hdr_push = 1; tick();
        end
    endtask

    task automatic add_rec(int t, int n);
        push_hdr(n, t * 256);
        unc_inj_type = 5'(t); unc_inj = 1; tick();
    endtask

    task automatic wr_unc(logic [31:0] v);
        wr_data = v; unc_wr = 1; tick();
    endtask

    task automatic peek_hdr(int idx, logic [31:0] exp, string tag);
        hdr_sel = 5'(idx); #1;
        chk(tag, 64'(hdr_log_word), 64'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: cycles=200000 expected completion earlier");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R11 reset state
        chk("R11 unc reset", 64'(unc_status), 64'h0);
        chk("R11 cor reset", 64'(cor_status), 64'h0);
        chk("R11 ptr reset", 64'(first_err_ptr), 64'd63);
        chk("R11 ovf reset", 64'(queue_ovf), 64'h0);

        // R3 first record loads pointer and header
        push_hdr(4, 3 * 256);
        unc_inj_type = 5'd3; unc_inj = 1; tick();
        chk("R10 accept pulse high", 64'(unc_accept), 64'h1);
        chk("R3 ptr", 64'(first_err_ptr), 64'd3);
        peek_hdr(2, 32'h302, "R3 hdr word 2");
        peek_hdr(5, 32'h0, "R3 hdr zero fill");
        tick();
        chk("R10 accept pulse one cycle", 64'(unc_accept), 64'h0);

        add_rec(7, 2); add_rec(3, 1); add_rec(12, 3);
        chk("R7 union", 64'(unc_status), 64'h1088);

        // R1 masked record dropped
        unc_mask = 32'h200;
        add_rec(9, 2);
        chk("R1 masked status", 64'(unc_status), 64'h1088);
        chk("R1 masked no accept", 64'(unc_accept), 64'h0);
        unc_mask = '0;

        // R4 head-only removal while another type-3 record waits
        wr_unc(32'h8);
        chk("R4 status keeps 3", 64'(unc_status), 64'h1088);
        chk("R6 ptr reload", 64'(first_err_ptr), 64'd7);
        peek_hdr(1, 32'h701, "R6 hdr reload");

        // R5 match removal of 3 and 12
        wr_unc(32'h1008);
        chk("R5 status", 64'(unc_status), 64'h80);
        chk("R5 ptr", 64'(first_err_ptr), 64'd7);

        // R6 empty queue
        wr_unc(32'h80);
        chk("R6 empty ptr", 64'(first_err_ptr), 64'd63);
        peek_hdr(0, 32'h0, "R6 empty hdr");

        // R9 fill then overflow
        for (int t = 0; t < 8; t++) add_rec(t, 1);
        add_rec(20, 1);
        chk("R9 full status", 64'(unc_status), 64'hFF);
        chk("R9 ovf set", 64'(queue_ovf), 64'h1);

        // R12 write and inject in one cycle on a full queue
        push_hdr(1, 21 * 256);
        wr_data = 32'h1; unc_wr = 1; unc_inj_type = 5'd21; unc_inj = 1; tick();
        chk("R12 appended", 64'(unc_status), 64'h002000FE);
        chk("R12 ptr", 64'(first_err_ptr), 64'd1);
        chk("R12 accept", 64'(unc_accept), 64'h1);
        wr_unc(32'hFFFFFFFF);
        chk("R5 clear all", 64'(unc_status), 64'h0);

        // R2 length limit
        add_rec(5, 33);
        chk("R2 overlong err", 64'(hdr_len_err), 64'h1);
        chk("R2 overlong dropped", 64'(unc_status), 64'h0);
        add_rec(5, 32);
        chk("R2 full length kept", 64'(unc_status), 64'h20);
        peek_hdr(31, 32'h51F, "R2 last dword");
        wr_unc(32'h20);

        // R8 correctable
        cor_inj_type = 5'd4; cor_inj = 1; tick();
        chk("R8 cor set", 64'(cor_status), 64'h10);
        cor_mask = 32'h40; cor_inj_type = 5'd6; cor_inj = 1; tick();
        chk("R8 cor masked", 64'(cor_status), 64'h10);
        cor_mask = '0;
        cor_inj_type = 5'd9; cor_inj = 1; tick();
        wr_data = 32'h10; cor_wr = 1; tick();
        chk("R8 cor w1c", 64'(cor_status), 64'h200);
        wr_data = 32'h10; cor_wr = 1; cor_inj_type = 5'd4; cor_inj = 1; tick();
        chk("R8 set wins", 64'(cor_status), 64'h210);

        // Random phase compared with the model every clock
        for (int n = 0; n < 3000; n++) begin
            hdr_push = ($urandom % 3) == 0;
            hdr_word = $urandom;
            unc_inj = ($urandom % 4) == 0;
            unc_inj_type = 5'($urandom % 8);
            unc_mask = (($urandom % 8) == 0) ? (32'd1 << ($urandom % 8)) : '0;
            unc_wr = ($urandom % 5) == 0;
            if ($urandom % 2) wr_data = (m_type.size() > 0) ? (32'd1 << m_type[0]) : '0;
            else wr_data = (32'd1 << ($urandom % 8)) | (32'd1 << ($urandom % 8));
            cor_inj = ($urandom % 4) == 0;
            cor_inj_type = 5'($urandom);
            cor_mask = (($urandom % 6) == 0) ? $urandom : '0;
            cor_wr = ($urandom % 6) == 0;
            hdr_sel = 5'($urandom);
            tick();
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule